// File: doc/BRIEF.md
# Programmable-Priority Interrupt Level Masker

This block holds a current interrupt level and turns a priority order loaded by software into the enable word for an edge-capture interrupt controller. Software writes an ordered list of source numbers into a small table. The list starts with the most urgent source and ends with a terminator entry of value -1. A commit command checks the list. If the list is well formed, the block turns it into a rank for every source. Sources that are not in the list rank after every listed source, and among themselves the lower source number ranks first.

The level works as a threshold on rank. At level k, the enabled sources are exactly those whose rank is below k. Level 0 therefore shuts off every source, and level N opens all of them. The enable word sent to the capture controller is formed as follows: the level mask is ANDed with the IRQ-enable bits, and the FIQ-enable bits are then ORed in. As a result, a source with its FIQ enable set is never held back by the level.

A service command picks the most urgent request that is pending and currently enabled. It then does four things: it pulses a clear for that request, reports the source and its vector number, lowers the level to the rank of that source, and returns the old level. A later restore command writes the old level back.

Top module: `prio_lvl_mask`

## Requirements
- R1: After reset, the level is 0, every rank equals the source number, and `loadErr` is 0. The enable word therefore equals `fiqEn` alone.
- R2: A level-set command (cmdOp 0) with a value from 0 to N makes the enable word, from the following cycle, equal to (sources with rank below that value AND `irqEn`) OR `fiqEn`. The value N enables every IRQ-enabled source.
- R3: A committed list gives each listed source the rank equal to its table position (position 0 is most urgent). Level k therefore enables exactly the first k listed sources.
- R4: Sources that are not listed take the ranks after the listed count, in ascending source-number order. A list that is only a terminator restores the rule that the lowest source number is most urgent.
- R5: A service command (cmdOp 1) considers only the requests that are pending, IRQ-enabled and below the current level. Among these it picks the one with the lowest rank, and the new level becomes that source's rank.
- R6: Every bit set in `fiqEn` is set in the enable word at every level.
- R7: A successful service pulses `svcHit` for one cycle. In that same cycle, `clrMask` is one-hot on the chosen source, and `srcId` holds the source number.
- R8: The service result reports `prevLevel` as the level before the service. A restore command (cmdOp 3) with that value puts the enable word back.
- R9: A commit command (cmdOp 2) rejects the table and sets `loadErr` in three cases: no terminator is present within N entries, an entry before the terminator is negative or not below N, or two entries before the terminator are equal. A rejected table leaves the ranks unchanged. An accepted commit clears `loadErr`.
- R10: A level-set or restore value above N leaves the level unchanged. The enable word is still recomputed from the current `irqEn` and `fiqEn`.
- R11: When no qualifying request exists, a service command pulses `svcNone`, keeps `clrMask` at 0, and leaves the level unchanged.
- R12: `vecNum` equals VEC_BASE plus the chosen source number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tblWe | input | 1 | Write strobe for the priority table |
| tblAddr | input | $clog2(NUM_SRC) | Table position to write |
| tblData | input | $clog2(NUM_SRC)+2 | Signed entry (source number, or -1 as terminator) |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 0 set level, 1 service, 2 commit table, 3 restore level |
| cmdLevel | input | $clog2(NUM_SRC+1) | Level argument for set and restore |
| irqEn | input | NUM_SRC | Per-source IRQ enable |
| fiqEn | input | NUM_SRC | Per-source FIQ enable (not subject to the level) |
| pendReq | input | NUM_SRC | Pending requests from the capture latches |
| enWord | output | NUM_SRC | Effective enable word |
| svcHit | output | 1 | One-cycle pulse: a request was chosen |
| svcNone | output | 1 | One-cycle pulse: no qualifying request was found |
| srcId | output | $clog2(NUM_SRC) | Chosen source |
| vecNum | output | VEC_W | Vector number of the chosen source |
| prevLevel | output | $clog2(NUM_SRC+1) | Level before the last successful service |
| clrMask | output | NUM_SRC | One-cycle clear for the chosen request |
| loadErr | output | 1 | Result of the last commit |

## Verification
The bench builds the block with NUM_SRC = 8 and VEC_BASE = 16. With these values the level argument is 4 bits wide, so the bench can drive the out-of-range values 9 to 15. The table entries are 5 bits wide, so an entry of 9 can be written and must be rejected. Eight sources also keep every rank and mask hand-computable, which lets the bench cover several cases by name: a partial list with unlisted sources placed after it, a duplicate, an out-of-range entry, a full list with no terminator, and the empty list. The vector base is nonzero, so a design that drops the offset gives a wrong vector number.

// File: rtl/prio_lvl_pkg.sv
package prio_lvl_pkg;
  typedef enum logic [1:0] {
    OP_SETLVL  = 2'd0,
    OP_SERVICE = 2'd1,
    OP_COMMIT  = 2'd2,
    OP_RESTORE = 2'd3
  } prioOp_e;

  typedef struct packed {
    logic doLevel;
    logic doSvc;
    logic doCommit;
  } prioStb_t;
endpackage

// File: rtl/prio_lvl_ctrl.sv
module prio_lvl_ctrl
  import prio_lvl_pkg::*;
(
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  output prioStb_t   stb
);
  prioOp_e op;
  assign op = prioOp_e'(cmdOp);

  always_comb begin
    stb = '0;
    if (cmdValid) begin
      unique case (op)
        OP_SETLVL, OP_RESTORE: stb.doLevel  = 1'b1;
        OP_SERVICE:            stb.doSvc    = 1'b1;
        OP_COMMIT:             stb.doCommit = 1'b1;
        default:               stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/prio_lvl_dp.sv
module prio_lvl_dp
  import prio_lvl_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int VEC_BASE = 16,
  parameter int VEC_W    = 8,
  localparam int SW = $clog2(NUM_SRC),
  localparam int EW = SW + 2,
  localparam int LW = $clog2(NUM_SRC + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  prioStb_t             stb,
  input  logic [LW-1:0]        cmdLevel,
  input  logic                 tblWe,
  input  logic [SW-1:0]        tblAddr,
  input  logic signed [EW-1:0] tblData,
  input  logic [NUM_SRC-1:0]   irqEn,
  input  logic [NUM_SRC-1:0]   fiqEn,
  input  logic [NUM_SRC-1:0]   pendReq,
  output logic [NUM_SRC-1:0]   enWord,
  output logic                 svcHit,
  output logic                 svcNone,
  output logic [SW-1:0]        srcId,
  output logic [VEC_W-1:0]     vecNum,
  output logic [LW-1:0]        prevLevel,
  output logic [NUM_SRC-1:0]   clrMask,
  output logic                 loadErr
);
  localparam logic signed [EW-1:0] TERM  = '1;
  localparam logic signed [EW-1:0] NSRC  = EW'(NUM_SRC);
  localparam logic [LW-1:0]        LVMAX = LW'(NUM_SRC);

  logic signed [EW-1:0] tbl  [NUM_SRC];
  logic [SW-1:0]        rank [NUM_SRC];
  logic [SW-1:0]        rankNew [NUM_SRC];
  logic [LW-1:0]        level, levelNext;

  // list validation and rank construction
  logic          termFound, badEntry, listOk;
  logic [SW:0]   termIdx, nextRank;
  logic [NUM_SRC-1:0] listed;

  always_comb begin
    termFound = 1'b0;
    termIdx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!termFound && tbl[i] == TERM) begin
        termFound = 1'b1;
        termIdx   = (SW+1)'(i);
      end
    end
    badEntry = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if ((SW+1)'(i) < termIdx) begin
        if (tbl[i] < 0 || tbl[i] >= NSRC) badEntry = 1'b1;
        for (int j = i + 1; j < NUM_SRC; j++)
          if ((SW+1)'(j) < termIdx && tbl[j] == tbl[i]) badEntry = 1'b1;
      end
    end
    listOk = termFound && !badEntry;

    listed = '0;
    for (int s = 0; s < NUM_SRC; s++) rankNew[s] = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if ((SW+1)'(i) < termIdx) begin
        listed[tbl[i][SW-1:0]]  = 1'b1;
        rankNew[tbl[i][SW-1:0]] = SW'(i);
      end
    end
    nextRank = termIdx;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (!listed[s]) begin
        rankNew[s] = nextRank[SW-1:0];
        nextRank   = nextRank + 1'b1;
      end
    end
  end

  // request scan at the current level
  logic [NUM_SRC-1:0] curMask, nextMask, cand;
  logic               found;
  logic [SW-1:0]      bestSrc, bestRank;

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) curMask[s] = LW'(rank[s]) < level;
    cand     = pendReq & irqEn & curMask;
    found    = 1'b0;
    bestSrc  = '0;
    bestRank = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (cand[s] && (!found || rank[s] < bestRank)) begin
        found    = 1'b1;
        bestSrc  = SW'(s);
        bestRank = rank[s];
      end
    end
  end

  always_comb begin
    levelNext = level;
    if (stb.doLevel && cmdLevel <= LVMAX) levelNext = cmdLevel;
    else if (stb.doSvc && found)          levelNext = LW'(bestRank);
    for (int s = 0; s < NUM_SRC; s++) nextMask[s] = LW'(rank[s]) < levelNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        tbl[i]  <= TERM;
        rank[i] <= SW'(i);
      end
      level     <= '0;
      enWord    <= '0;
      svcHit    <= 1'b0;
      svcNone   <= 1'b0;
      srcId     <= '0;
      vecNum    <= '0;
      prevLevel <= '0;
      clrMask   <= '0;
      loadErr   <= 1'b0;
    end else begin
      if (tblWe) tbl[tblAddr] <= tblData;
      if (stb.doCommit) begin
        loadErr <= !listOk;
        if (listOk) for (int s = 0; s < NUM_SRC; s++) rank[s] <= rankNew[s];
      end
      level   <= levelNext;
      enWord  <= (nextMask & irqEn) | fiqEn;
      svcHit  <= stb.doSvc && found;
      svcNone <= stb.doSvc && !found;
      clrMask <= '0;
      if (stb.doSvc && found) begin
        srcId     <= bestSrc;
        vecNum    <= VEC_W'(VEC_BASE) + VEC_W'(bestSrc);
        prevLevel <= level;
        clrMask   <= NUM_SRC'(1) << bestSrc;
      end
    end
  end

  // checks beside the logic they guard
  assert_clr_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    svcHit |-> ($onehot0(clrMask) && clrMask != '0));
  assert_clr_was_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    svcHit |-> ((clrMask & $past(pendReq)) == clrMask));
  assert_hit_none_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(svcHit && svcNone));
  assert_none_keeps_level_R11: assert property (@(posedge clk) disable iff (!rstN)
    svcNone |-> (level == $past(level)) && clrMask == '0);
  assert_svc_lowers_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    svcHit |-> (level < prevLevel));
  assert_fiq_bypass_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ((enWord & $past(fiqEn)) == $past(fiqEn)));
  assert_level_in_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVMAX);
endmodule

// File: rtl/prio_lvl_mask.sv
module prio_lvl_mask
  import prio_lvl_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int VEC_BASE = 16,
  parameter int VEC_W    = 8,
  localparam int SW = $clog2(NUM_SRC),
  localparam int EW = SW + 2,
  localparam int LW = $clog2(NUM_SRC + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tblWe,
  input  logic [SW-1:0]        tblAddr,
  input  logic signed [EW-1:0] tblData,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  input  logic [LW-1:0]        cmdLevel,
  input  logic [NUM_SRC-1:0]   irqEn,
  input  logic [NUM_SRC-1:0]   fiqEn,
  input  logic [NUM_SRC-1:0]   pendReq,
  output logic [NUM_SRC-1:0]   enWord,
  output logic                 svcHit,
  output logic                 svcNone,
  output logic [SW-1:0]        srcId,
  output logic [VEC_W-1:0]     vecNum,
  output logic [LW-1:0]        prevLevel,
  output logic [NUM_SRC-1:0]   clrMask,
  output logic                 loadErr
);
  prioStb_t stb;

  prio_lvl_ctrl u_ctrl (
    .cmdValid(cmdValid),
    .cmdOp   (cmdOp),
    .stb     (stb)
  );

  prio_lvl_dp #(
    .NUM_SRC (NUM_SRC),
    .VEC_BASE(VEC_BASE),
    .VEC_W   (VEC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cmdLevel (cmdLevel),
    .tblWe    (tblWe),
    .tblAddr  (tblAddr),
    .tblData  (tblData),
    .irqEn    (irqEn),
    .fiqEn    (fiqEn),
    .pendReq  (pendReq),
    .enWord   (enWord),
    .svcHit   (svcHit),
    .svcNone  (svcNone),
    .srcId    (srcId),
    .vecNum   (vecNum),
    .prevLevel(prevLevel),
    .clrMask  (clrMask),
    .loadErr  (loadErr)
  );
endmodule

// File: tb/prio_lvl_mask_tb.sv
`timescale 1ns/1ps
module prio_lvl_mask_tb;
  localparam int N  = 8;
  localparam int VB = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tblWe = 1'b0;
  logic [2:0] tblAddr = '0;
  logic signed [4:0] tblData = '0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [3:0] cmdLevel = '0;
  logic [N-1:0] irqEn = '0, fiqEn = '0, pendReq = '0;
  logic [N-1:0] enWord, clrMask;
  logic svcHit, svcNone, loadErr;
  logic [2:0] srcId;
  logic [7:0] vecNum;
  logic [3:0] prevLevel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    logic       hit;
    logic [2:0] src;
    logic [7:0] vec;
    logic [3:0] prev;
    logic [N-1:0] clr;
    string      tag;
  } svcExp_t;
  svcExp_t expQ[$];

  always #2.5 clk = ~clk;

  prio_lvl_mask #(.NUM_SRC(N), .VEC_BASE(VB), .VEC_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .tblWe(tblWe), .tblAddr(tblAddr), .tblData(tblData),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdLevel(cmdLevel),
    .irqEn(irqEn), .fiqEn(fiqEn), .pendReq(pendReq),
    .enWord(enWord), .svcHit(svcHit), .svcNone(svcNone), .srcId(srcId),
    .vecNum(vecNum), .prevLevel(prevLevel), .clrMask(clrMask), .loadErr(loadErr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [3:0] lv);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdLevel = lv;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic wr(input int addr, input int val);
    @(negedge clk);
    tblWe = 1'b1; tblAddr = 3'(addr); tblData = 5'(val);
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  task automatic pushSvc(input logic hit, input int src, input int prev, input string tag);
    svcExp_t e;
    e.hit = hit; e.src = 3'(src); e.vec = 8'(VB + src); e.prev = 4'(prev);
    e.clr = hit ? N'(1) << src : '0; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compare service results against the queue
  always @(negedge clk) begin
    if (rstN && (svcHit || svcNone)) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL %s actual hit=%0b expected no result", "R7", svcHit);
      end else begin
        svcExp_t e;
        e = expQ.pop_front();
        chk({e.tag, " hit"}, 32'(svcHit), 32'(e.hit));
        chk({e.tag, " clr"}, 32'(clrMask), 32'(e.clr));
        if (e.hit) begin
          chk({e.tag, " src R7"},   32'(srcId),     32'(e.src));
          chk({e.tag, " vec R12"},  32'(vecNum),    32'(e.vec));
          chk({e.tag, " prev R8"},  32'(prevLevel), 32'(e.prev));
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected below 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset enWord", 32'(enWord), 32'h00);
    chk("R1 reset loadErr", 32'(loadErr), 32'h0);
    chk("R1 reset svcHit", 32'(svcHit), 32'h0);

    irqEn = 8'hFF;
    cmd(2'd0, 4'd8);  chk("R2 level N", 32'(enWord), 32'hFF);
    cmd(2'd0, 4'd3);  chk("R1 identity ranks level 3", 32'(enWord), 32'h07);
    fiqEn = 8'h80;
    cmd(2'd0, 4'd0);  chk("R6 fiq at level 0", 32'(enWord), 32'h80);
    fiqEn = 8'h00;

    // list {5,2,6}: ranks 5:0 2:1 6:2 0:3 1:4 3:5 4:6 7:7
    wr(0, 5); wr(1, 2); wr(2, 6);
    cmd(2'd2, 4'd0);  chk("R9 good list accepted", 32'(loadErr), 32'h0);
    cmd(2'd0, 4'd2);  chk("R3 level 2", 32'(enWord), 32'h24);
    cmd(2'd0, 4'd3);  chk("R3 level 3", 32'(enWord), 32'h64);
    cmd(2'd0, 4'd4);  chk("R4 unlisted after list", 32'(enWord), 32'h65);
    cmd(2'd0, 4'd5);  chk("R4 unlisted ascending", 32'(enWord), 32'h67);

    cmd(2'd0, 4'd8);
    pendReq = 8'h44;
    pushSvc(1'b1, 2, 8, "R5 pick by rank");
    cmd(2'd1, 4'd0);
    chk("R5 level after service", 32'(enWord), 32'h20);
    pendReq = 8'h00;
    cmd(2'd3, 4'd8);  chk("R8 restore", 32'(enWord), 32'hFF);

    pushSvc(1'b0, 0, 0, "R11 nothing pending");
    cmd(2'd1, 4'd0);
    chk("R11 level kept", 32'(enWord), 32'hFF);

    cmd(2'd0, 4'd1);
    pendReq = 8'h04;
    pushSvc(1'b0, 0, 0, "R5 masked by level");
    cmd(2'd1, 4'd0);
    chk("R5 masked level kept", 32'(enWord), 32'h20);
    pendReq = 8'h00;

    cmd(2'd0, 4'd8);
    irqEn = 8'h0F;
    cmd(2'd0, 4'd12); chk("R10 out of range rewrites word", 32'(enWord), 32'h0F);
    pendReq = 8'h08;
    irqEn = 8'h0F;
    pushSvc(1'b1, 3, 8, "R10 level stayed N");
    cmd(2'd1, 4'd0);
    chk("R5 level 5 after src3", 32'(enWord), 32'h07);
    pendReq = 8'h00;
    irqEn = 8'hFF;

    // rejected lists keep ranks
    wr(0, 3); wr(1, 3); wr(2, -1);
    cmd(2'd2, 4'd0);  chk("R9 duplicate rejected", 32'(loadErr), 32'h1);
    cmd(2'd0, 4'd1);  chk("R9 ranks kept", 32'(enWord), 32'h20);
    wr(0, 9); wr(1, -1);
    cmd(2'd2, 4'd0);  chk("R9 out of range rejected", 32'(loadErr), 32'h1);
    for (int i = 0; i < N; i++) wr(i, i);
    cmd(2'd2, 4'd0);  chk("R9 no terminator rejected", 32'(loadErr), 32'h1);
    cmd(2'd0, 4'd2);  chk("R9 ranks still kept", 32'(enWord), 32'h24);

    wr(0, -1);
    cmd(2'd2, 4'd0);  chk("R4 empty list accepted", 32'(loadErr), 32'h0);
    cmd(2'd0, 4'd3);  chk("R4 empty list lsb first", 32'(enWord), 32'h07);

    @(negedge clk);
    chk("R7 all service results seen", 32'(expQ.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule